// File: doc/BRIEF.md
# XOR-Indexed Bit Shuffler

This block reorders the bits of a data word under the control of a small block index. Output lane `i` carries input bit `i ^ sel`, where `sel` is the index that arrives with the word. The block sits on both sides of a bit-plane frame buffer. On the write side it spreads the bits of each pixel across separate memories. On the read side it puts bit-plane data back into block order. The mapping is its own inverse, so one circuit serves both directions.

The permutation is built as a butterfly of group swaps in two registered stages. The first stage swaps large groups (the 4-bit halves in the 8-bit case) under the upper select bits. The second stage is a 4:1 multiplexer for each lane and does the combined 2-bit and 1-bit swaps under the two low select bits. A valid flag travels alongside the data. The block accepts a new word on every clock cycle and returns each result exactly two cycles after it was accepted. Parameter `WORDS` places several independent shufflers side by side, each with its own select field. For example, four 8-bit words give a 32-bit path.

Top module: `xor_bit_shuffler`

## Requirements
- R1: With select value 0, the output word equals the input word bit for bit.
- R2: Select value 1 (only bit 0 set) exchanges the two bits of each adjacent pair, so 8'hA5 becomes 8'h5A.
- R3: Select value 2 (only bit 1 set) exchanges neighbouring 2-bit groups inside each nibble, so 8'h31 becomes 8'hC4.
- R4: Select value 4 (only bit 2 set) exchanges the two 4-bit halves, so 8'h12 becomes 8'h21.
- R5: Select value 7 reverses the bit order completely: input bit 0 goes to lane 7 and input bit 7 goes to lane 0.
- R6: For every select value s, output lane i carries input bit (i XOR s).
- R7: `out_valid` equals `in_valid` from exactly two rising clock edges earlier, and the matching `out_data` is the shuffled word from that same cycle.
- R8: The block accepts a new word on every cycle. A back-to-back stream gives a back-to-back stream of results with no gaps.
- R9: Shuffling a result a second time with the same select value returns the original word.
- R10: While `rst_n` is low, a rising edge clears both `out_valid` and `out_data` to 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the input word as valid in this cycle |
| in_sel | input | WORDS*SEL_W (3) | Block index for each word; word w uses bits [w*SEL_W +: SEL_W] |
| in_data | input | WORDS*DATA_W (8) | Input words; word w is bits [w*DATA_W +: DATA_W] |
| out_valid | output | 1 | `in_valid` delayed by two cycles |
| out_data | output | WORDS*DATA_W (8) | Shuffled words, two cycles after their input |

## Verification
The checker assumes that `in_sel` and `in_data` hold known values in every cycle after reset, including cycles where `in_valid` is low. This is because the data path is not gated by valid and the checker compares history that is two cycles old. Its properties start only after two clock edges with reset released, so the pipeline already holds post-reset inputs. The bench always drives defined values, including during bubbles and during reset. It changes inputs only on the falling edge, so every sampled word is stable around the rising edge.

// File: rtl/xshf_pkg.sv
package xshf_pkg;

   // Number of low select bits resolved by the fine (4:1) stage.
   localparam int unsigned FINE_W = 2;
   // Group size the fine stage works inside.
   localparam int unsigned FINE_GRP = 1 << FINE_W;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/xshf_coarse_stage.sv
module xshf_coarse_stage
   import xshf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SEL_W-1:0]  in_sel,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [FINE_W-1:0] out_fine_sel,
   output logic [DATA_W-1:0] out_data
);

   localparam int unsigned HI_W   = SEL_W - FINE_W;
   localparam int unsigned GROUPS = DATA_W / FINE_GRP;

   logic [HI_W-1:0]   hi_sel;
   logic [DATA_W-1:0] perm;

   assign hi_sel = in_sel[SEL_W-1:FINE_W];

   // Each group of FINE_GRP lanes takes the group whose index is its own XOR hi_sel.
   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [HI_W-1:0] src;
      assign src = HI_W'(g) ^ hi_sel;
      assign perm[g*FINE_GRP +: FINE_GRP] = in_data[src*FINE_GRP +: FINE_GRP];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_fine_sel <= '0;
         out_data     <= '0;
      end else begin
         out_valid    <= in_valid;
         out_fine_sel <= in_sel[FINE_W-1:0];
         out_data     <= perm;
      end
   end

endmodule

// File: rtl/xshf_fine_stage.sv
module xshf_fine_stage
   import xshf_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [FINE_W-1:0] in_sel,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   logic [DATA_W-1:0] perm;

   // One 4:1 multiplexer per lane, choosing inside the lane's own group.
   for (genvar l = 0; l < DATA_W; l++) begin : g_lane
      localparam int unsigned BASE = (l / FINE_GRP) * FINE_GRP;
      localparam logic [FINE_W-1:0] OFS = FINE_W'(l % FINE_GRP);
      logic [FINE_GRP-1:0] grp;
      assign grp     = in_data[BASE +: FINE_GRP];
      assign perm[l] = grp[OFS ^ in_sel];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_data  <= perm;
      end
   end

endmodule

// File: rtl/xor_bit_shuffler.sv
module xor_bit_shuffler
   import xshf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WORDS  = 1,
   parameter int unsigned SEL_W  = $clog2(DATA_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [WORDS*SEL_W-1:0]  in_sel,
   input  logic [WORDS*DATA_W-1:0] in_data,
   output logic                    out_valid,
   output logic [WORDS*DATA_W-1:0] out_data
);

   // Elaboration-time parameter checks.
   if (!is_pow2(DATA_W) || DATA_W < 8) begin : g_bad_width
      $error("xor_bit_shuffler: DATA_W must be a power of two, at least 8");
   end
   if (SEL_W != $clog2(DATA_W)) begin : g_bad_sel
      $error("xor_bit_shuffler: SEL_W must equal log2(DATA_W)");
   end
   if (WORDS < 1) begin : g_bad_words
      $error("xor_bit_shuffler: WORDS must be at least 1");
   end

   logic [WORDS-1:0] vld_w;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic              s1_valid;
      logic [FINE_W-1:0] s1_sel;
      logic [DATA_W-1:0] s1_data;

      xshf_coarse_stage #(
         .DATA_W (DATA_W),
         .SEL_W  (SEL_W)
      ) u_coarse (
         .clk          (clk),
         .rst_n        (rst_n),
         .in_valid     (in_valid),
         .in_sel       (in_sel[w*SEL_W +: SEL_W]),
         .in_data      (in_data[w*DATA_W +: DATA_W]),
         .out_valid    (s1_valid),
         .out_fine_sel (s1_sel),
         .out_data     (s1_data)
      );

      xshf_fine_stage #(
         .DATA_W (DATA_W)
      ) u_fine (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (s1_valid),
         .in_sel    (s1_sel),
         .in_data   (s1_data),
         .out_valid (vld_w[w]),
         .out_data  (out_data[w*DATA_W +: DATA_W])
      );
   end

   // Every word lane carries the same valid; word 0 drives the port.
   assign out_valid = vld_w[0];

endmodule

// File: rtl/xshf_checker.sv
module xshf_checker #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned WORDS  = 1,
   parameter int unsigned SEL_W  = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [WORDS*SEL_W-1:0]  in_sel,
   input logic [WORDS*DATA_W-1:0] in_data,
   input logic                    out_valid,
   input logic [WORDS*DATA_W-1:0] out_data
);

   localparam logic [SEL_W-1:0] ALL_ONES = '1;

   // Edges seen since reset was released, saturating at 2.
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (!rst_n)         warm <= 2'd0;
      else if (warm != 2) warm <= warm + 2'd1;
   end

   function automatic logic [WORDS*DATA_W-1:0] xmap(
      input logic [WORDS*DATA_W-1:0] d,
      input logic [WORDS*SEL_W-1:0]  s
   );
      logic [WORDS*DATA_W-1:0] r;
      r = '0;
      for (int w = 0; w < WORDS; w++)
         for (int i = 0; i < DATA_W; i++)
            r[w*DATA_W + i] =
               d[w*DATA_W + int'(SEL_W'(i) ^ s[w*SEL_W +: SEL_W])];
      return r;
   endfunction

   function automatic logic [WORDS*DATA_W-1:0] rev_all(
      input logic [WORDS*DATA_W-1:0] d
   );
      logic [WORDS*DATA_W-1:0] r;
      for (int w = 0; w < WORDS; w++)
         for (int i = 0; i < DATA_W; i++)
            r[w*DATA_W + i] = d[w*DATA_W + DATA_W - 1 - i];
      return r;
   endfunction

   // R7: valid comes out exactly two edges later
   a_r7_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2) |-> (out_valid == $past(in_valid, 2)));

   // R6: every lane carries input bit lane XOR select
   a_r6_lane_map: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2 && out_valid) |-> (out_data == xmap($past(in_data, 2), $past(in_sel, 2))));

   // R1: a select of zero passes the word through unchanged
   a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2 && out_valid && $past(in_sel, 2) == '0) |-> (out_data == $past(in_data, 2)));

   // R5: a select of all ones reverses the word
   a_r5_reverse: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2 && out_valid && $past(in_sel, 2) == {WORDS{ALL_ONES}})
      |-> (out_data == rev_all($past(in_data, 2))));

   // R9: mapping the result again with the same select restores the input
   a_r9_self_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2 && out_valid) |-> (xmap(out_data, $past(in_sel, 2)) == $past(in_data, 2)));

   // R10: the first edge after reset release shows cleared outputs
   a_r10_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 0) |-> (!out_valid && out_data == '0));

endmodule

bind xor_bit_shuffler xshf_checker #(
   .DATA_W (DATA_W),
   .WORDS  (WORDS),
   .SEL_W  (SEL_W)
) u_xshf_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sel    (in_sel),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/tb_xor_bit_shuffler.sv
module tb_xor_bit_shuffler;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] in_sel = '0;
   logic [7:0] in_data = '0;
   logic       out_valid;
   logic [7:0] out_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   xor_bit_shuffler #(.DATA_W(8), .WORDS(1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sel    (in_sel),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   typedef struct packed {
      logic       v;
      logic [2:0] sel;
      logic [7:0] din;
      logic [7:0] dout;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 3'd0, 8'h81, 8'h81},  // R1
      '{1'b1, 3'd0, 8'h3C, 8'h3C},  // R1
      '{1'b1, 3'd1, 8'hA5, 8'h5A},  // R2
      '{1'b1, 3'd1, 8'h01, 8'h02},  // R2
      '{1'b0, 3'd7, 8'hFF, 8'h00},  // R7 bubble
      '{1'b1, 3'd2, 8'h31, 8'hC4},  // R3
      '{1'b1, 3'd2, 8'h03, 8'h0C},  // R3
      '{1'b1, 3'd4, 8'h12, 8'h21},  // R4
      '{1'b1, 3'd7, 8'h01, 8'h80},  // R5
      '{1'b1, 3'd7, 8'hC4, 8'h23},  // R5
      '{1'b1, 3'd3, 8'h01, 8'h08},  // R6
      '{1'b1, 3'd5, 8'h01, 8'h20},  // R6
      '{1'b1, 3'd6, 8'h02, 8'h80},  // R6
      '{1'b0, 3'd0, 8'h55, 8'h00}   // R7 bubble
   };

   // Model of R6, written from the requirement: lane i takes bit i^s.
   function automatic logic [7:0] model(input logic [7:0] d, input logic [2:0] s);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = d[3'(i) ^ s];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] s, input logic [7:0] d);
      in_valid = v;
      in_sel   = s;
      in_data  = d;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R8 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] hist_d [2];
      logic [2:0] hist_s [2];
      logic       hist_v [2];
      logic [7:0] mid;

      // R10: outputs cleared while reset is held, with live inputs present
      drive(1'b1, 3'd5, 8'hE7);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 valid in reset", 32'(out_valid), 0);
      chk(out_data == 8'h00, "R10 data in reset", 32'(out_data), 0);
      drive(1'b0, 3'd0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk, one vector per cycle (R1-R7 coverage, R8 back to back)
      for (int k = 0; k < NV + 2; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            chk(out_valid == VEC[k-2].v, "R7 valid latency",
                32'(out_valid), 32'(VEC[k-2].v));
            if (VEC[k-2].v)
               chk(out_data == VEC[k-2].dout, "R1..R6 table word",
                   32'(out_data), 32'(VEC[k-2].dout));
         end
         if (k < NV) drive(VEC[k].v, VEC[k].sel, VEC[k].din);
         else        drive(1'b0, 3'd0, 8'h00);
      end

      // R6 and R8: full sweep, streaming every cycle
      hist_v[0] = 1'b0; hist_v[1] = 1'b0;
      hist_d[0] = '0;   hist_d[1] = '0;
      hist_s[0] = '0;   hist_s[1] = '0;
      for (int k = 0; k < 2048 + 2; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            chk(out_valid == 1'b1, "R8 stream valid", 32'(out_valid), 1);
            chk(out_data == model(hist_d[1], hist_s[1]), "R6 sweep",
                32'(out_data), 32'(model(hist_d[1], hist_s[1])));
         end
         hist_d[1] = hist_d[0]; hist_s[1] = hist_s[0]; hist_v[1] = hist_v[0];
         if (k < 2048) begin
            drive(1'b1, 3'(k / 256), 8'(k % 256));
            hist_d[0] = 8'(k % 256); hist_s[0] = 3'(k / 256); hist_v[0] = 1'b1;
         end else begin
            drive(1'b0, 3'd0, 8'h00);
         end
      end
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 valid drops after stream", 32'(out_valid), 0);

      // R9: feed each result back with the same select
      for (int s = 0; s < 8; s++) begin
         drive(1'b1, 3'(s), 8'h9C ^ 8'(s * 17));
         @(negedge clk);
         drive(1'b0, 3'(s), 8'h00);
         @(negedge clk);
         mid = out_data;
         drive(1'b1, 3'(s), mid);
         @(negedge clk);
         drive(1'b0, 3'd0, 8'h00);
         @(negedge clk);
         chk(out_data == (8'h9C ^ 8'(s * 17)), "R9 round trip",
             32'(out_data), 32'(8'h9C ^ 8'(s * 17)));
      end

      // R10: reset in the middle of traffic clears the pipeline
      drive(1'b1, 3'd7, 8'hF0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 valid after mid-run reset", 32'(out_valid), 0);
      chk(out_data == 8'h00, "R10 data after mid-run reset", 32'(out_data), 0);
      rst_n = 1'b1;
      drive(1'b0, 3'd0, 8'h00);
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule